// File: doc/BRIEF.md
# Critical-Word-First Line Refill Engine

This block fetches a missing four-word cache line from the next memory level after a read miss. The word the processor asked for is fetched first. The other three words follow in wrap-around order: critical word `w`, then `(w+1) mod 4`, `(w+2) mod 4` and `(w+3) mod 4`. Each returning word goes straight to the data-array write port. The first returning word is also handed to the processor on a one-cycle restart strobe, so execution can resume while the rest of the line fills in the background.

The line's tag is written in the cycle the miss is accepted. The line's valid bit is set only when the fourth word is written, and the completion pulse comes in the same cycle. While a refill runs, a probe port reports whether a processor access must stall. An access stalls only if it targets the line being filled and its word has not yet been written. Accesses to other lines never stall. A new miss that arrives while the engine is busy is not accepted. The requester sees `miss_hold` high and must present the miss again once `miss_hold` falls.

The request side is valid/ready. A request is transferred in a cycle where both `mreq_valid` and `mreq_ready` are high. While `mreq_ready` is low, `mreq_valid` stays high and `mreq_addr` does not change.

The response side has no back-pressure:
- the engine takes a word in every cycle where `mrsp_valid` is high;
- memory returns words in the order they were requested;
- memory answers only requests that have already been transferred;
- any number of idle cycles may separate two words.

Addresses are byte addresses with these fields:

| Bits | Field |
|------|-------|
| [1:0] | byte within the word |
| [3:2] | word within the line |
| [11:4] | line index |
| [31:12] | tag |

Top module: `refill_engine`

## Requirements
- R1: After reset the engine is idle. `miss_hold`, `mreq_valid`, `arr_we`, `crit_valid`, `refill_done`, `line_valid_set` and `cpu_probe_stall` are all low.
- R2: A `miss_start` seen while idle is accepted in that cycle. `tag_we` is high in the same cycle, with `tag_line` = `miss_addr[11:4]` and `tag_value` = `miss_addr[31:12]`. `miss_hold` is high from the next cycle on.
- R3: Each accepted miss with critical word `w` issues exactly four requests. Request k (k = 0..3) carries byte address {`miss_addr[31:4]`, `(w+k) mod 4`, 2'b00}. No request is issued after the fourth.
- R4: The k-th returning word (k = 0..3) is written in its arrival cycle. In that cycle `arr_we` is high, `arr_line` is the line index, `arr_word` = `(w+k) mod 4` and `arr_wdata` = `mrsp_data`. `arr_we` is low in every cycle without a response.
- R5: `crit_valid` is high for exactly one cycle per refill: the cycle of the first returning word. In that cycle `crit_data` equals that word.
- R6: `refill_done` and `line_valid_set` are high together for exactly one cycle per refill: the cycle of the fourth returning word. `miss_hold` is low in the next cycle.
- R7: Any number of idle cycles between returning words changes only the timing, never the order or content of the writes.
- R8: A `miss_start` while `miss_hold` is high is ignored. `tag_we` stays low, and the running refill's requests and writes are unchanged.
- R9: During a refill, `cpu_probe_stall` is high exactly when `cpu_probe_valid` is high, `cpu_probe_addr[31:4]` matches the refilling line, and the addressed word has not been written in an earlier cycle. A word already written, or an address in any other line, gives no stall.
- R10: While `mreq_valid` is high and `mreq_ready` is low, `mreq_valid` stays high and `mreq_addr` is unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_start | input | 1 | Read-miss start pulse |
| miss_addr | input | 32 | Byte address of the missed word |
| miss_hold | output | 1 | Engine busy; new misses are not accepted |
| tag_we | output | 1 | Tag write strobe, high when a miss is accepted |
| tag_line | output | 8 | Line index for the tag write |
| tag_value | output | 20 | Tag to write |
| mreq_valid | output | 1 | Word request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 32 | Byte address of the requested word |
| mrsp_valid | input | 1 | Returning word valid |
| mrsp_data | input | 32 | Returning word |
| arr_we | output | 1 | Data-array write strobe |
| arr_line | output | 8 | Data-array line index |
| arr_word | output | 2 | Word position within the line |
| arr_wdata | output | 32 | Data to write |
| crit_valid | output | 1 | Early-restart strobe |
| crit_data | output | 32 | Requested word for the processor |
| refill_done | output | 1 | Refill complete pulse |
| line_valid_set | output | 1 | Sets the valid bit of line `arr_line` |
| cpu_probe_valid | input | 1 | Processor access probe valid |
| cpu_probe_addr | input | 32 | Processor access byte address |
| cpu_probe_stall | output | 1 | Probed access must wait |

## Verification
Refills are run from every critical-word position, so a fixed or wrongly wrapped order shows up as a bad request address or write slot. The bench varies the gap between returning words (none, short, long) to separate counting of responses from counting of cycles, and holds `mreq_ready` low at intervals to catch address changes or skipped requests under back-pressure. Probes cycle through all four words of the refilling line plus a foreign line, which distinguishes stalling on "line busy" from stalling on "word not yet arrived". Back-to-back refills and a second miss during a refill check that counters clear and that a busy engine ignores new misses.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic {RF_IDLE = 1'b0, RF_FILL = 1'b1} rf_state_e;

  function automatic logic [7:0] wrap_pos(input logic [7:0] base, input logic [7:0] step,
                                          input int unsigned ofs_w);
    logic [7:0] mask;
    mask = 8'((1 << ofs_w) - 1);
    return (base + step) & mask;
  endfunction
endpackage

// File: rtl/refill_req_seq.sv
module refill_req_seq #(
  parameter int WORDS = 4,
  localparam int OFS_W = $clog2(WORDS),
  localparam int CNT_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [OFS_W-1:0] crit,
  input  logic             ready,
  output logic             valid,
  output logic [OFS_W-1:0] word
);
  logic [CNT_W-1:0] sent_q;

  assign valid = active && (sent_q < CNT_W'(WORDS));
  assign word  = crit + sent_q[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sent_q <= '0;
    else if (start)          sent_q <= '0;
    else if (valid && ready) sent_q <= sent_q + 1'b1;
  end

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(word)));
  assert_req_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !valid);
endmodule

// File: rtl/refill_rsp_track.sv
module refill_rsp_track #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int OFS_W = $clog2(WORDS),
  localparam int CNT_W = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic [OFS_W-1:0]  crit,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              we,
  output logic [OFS_W-1:0]  word,
  output logic [WORD_W-1:0] wdata,
  output logic              first,
  output logic              last,
  output logic [WORDS-1:0]  arrived
);
  logic [CNT_W-1:0] got_q;
  logic [WORDS-1:0] arrived_q;

  assign we      = active && rsp_valid && (got_q < CNT_W'(WORDS));
  assign word    = crit + got_q[OFS_W-1:0];
  assign wdata   = rsp_data;
  assign first   = we && (got_q == '0);
  assign last    = we && (got_q == CNT_W'(WORDS - 1));
  assign arrived = arrived_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q     <= '0;
      arrived_q <= '0;
    end else if (start) begin
      got_q     <= '0;
      arrived_q <= '0;
    end else if (we) begin
      got_q           <= got_q + 1'b1;
      arrived_q[word] <= 1'b1;
    end
  end

  assert_first_is_crit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    first |-> (we && word == crit));
  assert_no_rewrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !arrived_q[word]);
endmodule

// File: rtl/refill_probe_guard.sv
module refill_probe_guard #(
  parameter int LID_W = 28,
  parameter int WORDS = 4,
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic             busy,
  input  logic [LID_W-1:0] fill_line,
  input  logic [WORDS-1:0] arrived,
  input  logic             probe_valid,
  input  logic [LID_W-1:0] probe_line,
  input  logic [OFS_W-1:0] probe_word,
  output logic             stall
);
  logic same_line;
  assign same_line = (probe_line == fill_line);
  assign stall     = probe_valid && busy && same_line && !arrived[probe_word];
endmodule

// File: rtl/refill_engine.sv
module refill_engine #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8,
  parameter int WORDS  = 4,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W - BYTE_W,
  localparam int LID_W  = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_start,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_hold,
  output logic              tag_we,
  output logic [IDX_W-1:0]  tag_line,
  output logic [TAG_W-1:0]  tag_value,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              mrsp_valid,
  input  logic [WORD_W-1:0] mrsp_data,
  output logic              arr_we,
  output logic [IDX_W-1:0]  arr_line,
  output logic [OFS_W-1:0]  arr_word,
  output logic [WORD_W-1:0] arr_wdata,
  output logic              crit_valid,
  output logic [WORD_W-1:0] crit_data,
  output logic              refill_done,
  output logic              line_valid_set,
  input  logic              cpu_probe_valid,
  input  logic [ADDR_W-1:0] cpu_probe_addr,
  output logic              cpu_probe_stall
);
  import refill_pkg::*;

  rf_state_e        state_q;
  logic             busy, accept, last_wr;
  logic [LID_W-1:0] line_q;
  logic [OFS_W-1:0] crit_q, req_word;
  logic [WORDS-1:0] arrived;

  assign busy   = (state_q == RF_FILL);
  assign accept = miss_start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RF_IDLE;
      line_q  <= '0;
      crit_q  <= '0;
    end else if (accept) begin
      state_q <= RF_FILL;
      line_q  <= miss_addr[ADDR_W-1 -: LID_W];
      crit_q  <= miss_addr[BYTE_W +: OFS_W];
    end else if (last_wr) begin
      state_q <= RF_IDLE;
    end
  end

  assign miss_hold = busy;
  assign tag_we    = accept;
  assign tag_line  = miss_addr[BYTE_W + OFS_W +: IDX_W];
  assign tag_value = miss_addr[ADDR_W-1 -: TAG_W];

  refill_req_seq #(.WORDS(WORDS)) u_req (
    .clk(clk), .rst_n(rst_n), .start(accept), .active(busy), .crit(crit_q),
    .ready(mreq_ready), .valid(mreq_valid), .word(req_word)
  );
  assign mreq_addr = {line_q, req_word, {BYTE_W{1'b0}}};

  refill_rsp_track #(.WORD_W(WORD_W), .WORDS(WORDS)) u_rsp (
    .clk(clk), .rst_n(rst_n), .start(accept), .active(busy), .crit(crit_q),
    .rsp_valid(mrsp_valid), .rsp_data(mrsp_data), .we(arr_we), .word(arr_word),
    .wdata(arr_wdata), .first(crit_valid), .last(last_wr), .arrived(arrived)
  );
  assign arr_line       = line_q[IDX_W-1:0];
  assign crit_data      = mrsp_data;
  assign refill_done    = last_wr;
  assign line_valid_set = last_wr;

  refill_probe_guard #(.LID_W(LID_W), .WORDS(WORDS)) u_guard (
    .busy(busy), .fill_line(line_q), .arrived(arrived), .probe_valid(cpu_probe_valid),
    .probe_line(cpu_probe_addr[ADDR_W-1 -: LID_W]),
    .probe_word(cpu_probe_addr[BYTE_W +: OFS_W]), .stall(cpu_probe_stall)
  );

  assert_done_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |=> !miss_hold);
  assert_accept_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> miss_hold);
  assert_busy_no_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_hold |-> !tag_we);
  assert_stall_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_probe_stall |-> miss_hold);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_hold |-> (!arr_we && !crit_valid && !refill_done));
endmodule

// File: tb/sim_refill_engine.sv
module sim_refill_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        miss_start = 0, mreq_ready = 0, mrsp_valid = 0, cpu_probe_valid = 0;
  logic [31:0] miss_addr = '0, mrsp_data = '0, cpu_probe_addr = '0;
  logic        miss_hold, tag_we, mreq_valid, arr_we, crit_valid, refill_done;
  logic        line_valid_set, cpu_probe_stall;
  logic [7:0]  tag_line, arr_line;
  logic [19:0] tag_value;
  logic [31:0] mreq_addr, arr_wdata, crit_data;
  logic [1:0]  arr_word;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  refill_engine u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic do_refill(input logic [31:0] addr, input int gap, input bit bp,
                           input bit second, input bit probe);
    logic [31:0] q[4];
    logic [3:0] written = '0;
    int sent = 0, got = 0, gapc = 0, cyc = 0;
    logic [1:0] w = addr[3:2];
    @(negedge clk);
    miss_start = 1; miss_addr = addr;
    #1;
    check("R2 tag_we", 32'(tag_we), 1);
    check("R2 tag_line", 32'(tag_line), 32'(addr[11:4]));
    check("R2 tag_value", 32'(tag_value), 32'(addr[31:12]));
    while (got < 4 && cyc < 300) begin
      @(negedge clk);
      cyc++;
      miss_start = 0; cpu_probe_valid = 0; mrsp_valid = 0;
      mreq_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (sent > got && gapc == 0) begin
        mrsp_valid = 1; mrsp_data = mem_word(q[got]);
      end
      if (second && cyc == 2) begin
        miss_start = 1; miss_addr = addr ^ 32'h0000_5550;
      end
      if (probe) begin
        cpu_probe_valid = 1;
        cpu_probe_addr = (cyc % 5 == 0) ? addr + 32'h10 : {addr[31:4], 2'(cyc), 2'b00};
      end
      #1;
      check("R2 hold", 32'(miss_hold), 1);
      if (second && cyc == 2) check("R8 ignored miss", 32'(tag_we), 0);
      if (probe) begin
        logic exp_st;
        exp_st = (cpu_probe_addr[31:4] == addr[31:4]) && !written[cpu_probe_addr[3:2]];
        check("R9 probe stall", 32'(cpu_probe_stall), 32'(exp_st));
      end
      if (mreq_valid) begin
        check("R3 request count", 32'(sent < 4), 1);
        check("R3 request addr", mreq_addr, {addr[31:4], 2'(w + 2'(sent)), 2'b00});
        if (mreq_ready && sent < 4) begin
          q[sent] = mreq_addr; sent++;
        end
      end else if (sent < 4) begin
        check("R10 valid dropped", 32'(mreq_valid), 1);
      end
      if (mrsp_valid) begin
        check("R4 write strobe", 32'(arr_we), 1);
        check("R4 write slot", 32'(arr_word), 32'(2'(w + 2'(got))));
        check("R4 write line", 32'(arr_line), 32'(addr[11:4]));
        check("R4 write data", arr_wdata, mrsp_data);
        check("R5 restart strobe", 32'(crit_valid), 32'(got == 0));
        if (got == 0) check("R5 restart data", crit_data, mem_word(addr & ~32'h3));
        check("R6 done", 32'(refill_done), 32'(got == 3));
        check("R6 valid set", 32'(line_valid_set), 32'(got == 3));
        written[arr_word] = 1'b1;
        got++; gapc = gap;
      end else begin
        check("R4 no stray write", 32'(arr_we), 0);
        check("R6 no early done", 32'(refill_done), 0);
        check("R5 no stray restart", 32'(crit_valid), 0);
        if (gapc > 0) gapc--;
      end
    end
    check("R7 all words returned", 32'(got), 4);
    @(negedge clk);
    miss_start = 0; mrsp_valid = 0; cpu_probe_valid = 0;
    #1;
    check("R6 hold released", 32'(miss_hold), 0);
    check("R3 no fifth request", 32'(mreq_valid), 0);
    check("R3 four requests", 32'(sent), 4);
  endtask

  task automatic t_reset();
    check("R1 hold", 32'(miss_hold), 0);
    check("R1 req", 32'(mreq_valid), 0);
    check("R1 write", 32'(arr_we), 0);
    check("R1 restart", 32'(crit_valid), 0);
    check("R1 done", 32'({refill_done, line_valid_set}), 0);
    cpu_probe_valid = 1; cpu_probe_addr = 32'h0000_1230;
    #1 check("R1 probe stall", 32'(cpu_probe_stall), 0);
    cpu_probe_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    do_refill(32'hABCD_E120, 0, 0, 0, 0);  // critical word 0, no gaps
    do_refill(32'h1234_5678, 2, 0, 0, 1);  // critical word 2, short gaps, probes
    do_refill(32'h0F0F_0A3C, 0, 1, 0, 1);  // critical word 3, back-pressure
    do_refill(32'h7777_0014, 5, 1, 1, 0);  // critical word 1, long gaps, second miss
    do_refill(32'h7777_0018, 1, 0, 1, 1);  // back-to-back on same line
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule